// File: doc/BRIEF.md
# Inactivity Auto-Sleep Rate Controller

This block picks the output data rate of a motion sensor's sampling engine. It chooses between the active rate code and a slower sleep rate code. In active mode it counts sample ticks for as long as no qualifying event arrives. The programmed inactivity period is an 8-bit duration. Each duration step is worth a fixed amount of time, so the number of sample ticks per step depends on the active rate. Once the period has passed with sleep enabled, the block enters sleep mode and presents the sleep rate code.

There are four event sources: transient, orientation, pulse and motion/freefall. Each source has an enable bit and a wake-select bit. Any enabled source restarts the inactivity timer. Only an enabled source whose wake-select bit is also set can bring the block back from sleep. Data-ready pulses and the block's own interrupt are not inputs, so they cannot restart the timer or wake the block. When the interrupt is enabled, every change of mode raises a flag, and the flag stays set until it is cleared.

Top module: `aslp_rate_ctrl`

## Requirements
- R1: After synchronous reset the block is in active mode (`asleep_o`=0), `irq_o` is 0 and `rate_o` equals `act_rate_i`.
- R2: Ticks per duration step depend on the active rate code: codes 0..7 give 256, 128, 64, 32, 16, 4, 2 and 1 ticks. With sleep enabled and duration D, the block enters sleep on the edge of the (D*T+1)-th consecutive tick that carries no qualifying event, where T is the ticks per step.
- R3: With duration 0 and sleep enabled, the first tick that carries no qualifying event puts the block to sleep.
- R4: While `sleep_en_i` is 0 the block never enters sleep. Clearing it while asleep returns the block to active on the next edge.
- R5: A pulse on `evt_i[k]` with `evt_en_i[k]`=1 restarts the inactivity count, and this takes precedence over a tick in the same cycle. A pulse on a source whose enable bit is 0 has no effect. Bit order: 0 transient, 1 orientation, 2 pulse, 3 motion/freefall.
- R6: In sleep, an event with both its enable bit and its wake bit set returns the block to active on the next edge. An enabled event whose wake bit is clear leaves the block asleep.
- R7: `rate_o` equals `sleep_rate_i` while asleep and `act_rate_i` otherwise. It switches on the same edge as the mode.
- R8: With `irq_en_i`=1, each entry into sleep and each return to active sets `irq_o` on that edge. With `irq_en_i`=0, a transition leaves `irq_o` unchanged.
- R9: `irq_o` stays set until `irq_clr_i` is high for a cycle. A transition in the same cycle as the clear keeps it set.
- R10: After a return to active, the inactivity count starts again from zero, so a full period is needed before the next sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per output sample |
| act_rate_i | input | 3 | Active rate code (0 fastest .. 7 slowest) |
| sleep_rate_i | input | 3 | Rate code used while asleep |
| sleep_en_i | input | 1 | Permits the move to sleep |
| duration_i | input | 8 | Inactivity period in duration steps |
| evt_i | input | 4 | Event pulses from the four detectors |
| evt_en_i | input | 4 | Per-source enable mask |
| evt_wake_i | input | 4 | Per-source wake-select mask |
| irq_en_i | input | 1 | Enables the transition flag |
| irq_clr_i | input | 1 | One-cycle clear for the flag |
| asleep_o | output | 1 | 1 while in sleep mode |
| rate_o | output | 3 | Selected rate code |
| irq_o | output | 1 | Sticky transition flag |

## Verification
The bench measures the number of ticks to sleep at every rate code with a small duration. An off-by-one in the prescaler or in the duration compare would shift the moment of sleep by a whole step or by one tick. It checks a duration of zero, where a design that waits for a full step would sleep late. It also checks a tick that arrives together with an event, which must restart the count rather than advance it. In sleep it separates enabled sources from wake-selected ones, so a design that wakes on any enabled event would return to active too early. It drives a clear in the same cycle as a transition, where a design that gives the clear priority would drop the flag. It also confirms that a second sleep after a wake needs the full period again.

// File: rtl/aslp_pkg.sv
package aslp_pkg;

    localparam int unsigned N_SRC  = 4;
    localparam int unsigned RATE_W = 3;
    localparam int unsigned DUR_W  = 8;
    localparam int unsigned PRE_W  = 9;

    typedef enum logic {
        MODE_ACTIVE = 1'b0,
        MODE_SLEEP  = 1'b1
    } mode_e;

    typedef struct packed {
        logic restart;
        logic wake;
    } evt_sum_t;

    // Sample ticks that make up one duration step at a given active rate.
    function automatic logic [PRE_W-1:0] ticks_per_step(input logic [RATE_W-1:0] code);
        logic [PRE_W-1:0] n;
        case (code)
            3'd0:    n = 9'd256;
            3'd1:    n = 9'd128;
            3'd2:    n = 9'd64;
            3'd3:    n = 9'd32;
            3'd4:    n = 9'd16;
            3'd5:    n = 9'd4;
            3'd6:    n = 9'd2;
            default: n = 9'd1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/aslp_evt_qual.sv
module aslp_evt_qual
    import aslp_pkg::*;
#(
    parameter int unsigned NS = N_SRC
) (
    input  logic [NS-1:0] evt_i,
    input  logic [NS-1:0] en_i,
    input  logic [NS-1:0] wake_i,
    output evt_sum_t      sum_o
);

    logic [NS-1:0] hit_restart;
    logic [NS-1:0] hit_wake;

    for (genvar g = 0; g < NS; g++) begin : g_src
        assign hit_restart[g] = evt_i[g] & en_i[g];
        assign hit_wake[g]    = evt_i[g] & en_i[g] & wake_i[g];
    end

    always_comb begin
        sum_o.restart = |hit_restart;
        sum_o.wake    = |hit_wake;
    end

endmodule

// File: rtl/aslp_idle_timer.sv
module aslp_idle_timer
    import aslp_pkg::*;
#(
    parameter int unsigned RW = RATE_W,
    parameter int unsigned DW = DUR_W,
    parameter int unsigned PW = PRE_W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          hold_i,
    input  logic          tick_i,
    input  logic [RW-1:0] rate_i,
    input  logic [DW-1:0] duration_i,
    output logic          expire_o
);

    logic [PW-1:0] pre_q;
    logic [DW-1:0] steps_q;
    logic [PW-1:0] last_pre;

    assign last_pre = ticks_per_step(rate_i) - 1'b1;
    assign expire_o = tick_i && !hold_i && (steps_q >= duration_i);

    always_ff @(posedge clk_i) begin
        if (rst_i || hold_i || expire_o) begin
            pre_q   <= '0;
            steps_q <= '0;
        end else if (tick_i) begin
            if (pre_q >= last_pre) begin
                pre_q   <= '0;
                steps_q <= steps_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/aslp_mode_ctl.sv
module aslp_mode_ctl
    import aslp_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     expire_i,
    input  evt_sum_t evt_i,
    input  logic     sleep_en_i,
    input  logic     irq_en_i,
    input  logic     irq_clr_i,
    output mode_e    mode_o,
    output logic     irq_o
);

    mode_e mode_q, mode_d;
    logic  irq_q;
    logic  flip;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_ACTIVE: if (expire_i && sleep_en_i) mode_d = MODE_SLEEP;
            MODE_SLEEP:  if (evt_i.wake || !sleep_en_i) mode_d = MODE_ACTIVE;
            default:     mode_d = MODE_ACTIVE;
        endcase
    end

    assign flip = (mode_d != mode_q);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q <= MODE_ACTIVE;
            irq_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            if (flip && irq_en_i)
                irq_q <= 1'b1;
            else if (irq_clr_i)
                irq_q <= 1'b0;
        end
    end

    assign mode_o = mode_q;
    assign irq_o  = irq_q;

endmodule

// File: rtl/aslp_rate_ctrl.sv
module aslp_rate_ctrl
    import aslp_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic [RATE_W-1:0] act_rate_i,
    input  logic [RATE_W-1:0] sleep_rate_i,
    input  logic              sleep_en_i,
    input  logic [DUR_W-1:0]  duration_i,
    input  logic [N_SRC-1:0]  evt_i,
    input  logic [N_SRC-1:0]  evt_en_i,
    input  logic [N_SRC-1:0]  evt_wake_i,
    input  logic              irq_en_i,
    input  logic              irq_clr_i,
    output logic              asleep_o,
    output logic [RATE_W-1:0] rate_o,
    output logic              irq_o
);

    evt_sum_t evt_sum;
    mode_e    mode;
    logic     expire;
    logic     hold;

    aslp_evt_qual #(.NS(N_SRC)) u_qual (
        .evt_i  (evt_i),
        .en_i   (evt_en_i),
        .wake_i (evt_wake_i),
        .sum_o  (evt_sum)
    );

    // The count is held at zero while asleep, while sleep is disabled,
    // and whenever an enabled event arrives.
    assign hold = evt_sum.restart || !sleep_en_i || (mode == MODE_SLEEP);

    aslp_idle_timer #(.RW(RATE_W), .DW(DUR_W), .PW(PRE_W)) u_timer (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .hold_i     (hold),
        .tick_i     (tick_i),
        .rate_i     (act_rate_i),
        .duration_i (duration_i),
        .expire_o   (expire)
    );

    aslp_mode_ctl u_mode (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .expire_i   (expire),
        .evt_i      (evt_sum),
        .sleep_en_i (sleep_en_i),
        .irq_en_i   (irq_en_i),
        .irq_clr_i  (irq_clr_i),
        .mode_o     (mode),
        .irq_o      (irq_o)
    );

    assign asleep_o = (mode == MODE_SLEEP);
    assign rate_o   = asleep_o ? sleep_rate_i : act_rate_i;

endmodule

// File: rtl/aslp_rate_ctrl_chk.sv
module aslp_rate_ctrl_chk
    import aslp_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic              tick_i,
    input logic [RATE_W-1:0] act_rate_i,
    input logic [RATE_W-1:0] sleep_rate_i,
    input logic              sleep_en_i,
    input logic [DUR_W-1:0]  duration_i,
    input logic [N_SRC-1:0]  evt_i,
    input logic [N_SRC-1:0]  evt_en_i,
    input logic [N_SRC-1:0]  evt_wake_i,
    input logic              irq_en_i,
    input logic              irq_clr_i,
    input logic              asleep_o,
    input logic [RATE_W-1:0] rate_o,
    input logic              irq_o
);

    p_reset_state_r1: assert property (@(posedge clk_i)
        rst_i |=> (!asleep_o && !irq_o));

    p_no_tick_no_sleep_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!asleep_o && !tick_i) |=> !asleep_o);

    p_disabled_stays_active_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !sleep_en_i |=> !asleep_o);

    p_event_restarts_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!asleep_o && |(evt_i & evt_en_i)) |=> !asleep_o);

    p_wake_event_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (asleep_o && |(evt_i & evt_en_i & evt_wake_i)) |=> !asleep_o);

    p_irq_on_sleep_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!asleep_o && irq_en_i) ##1 asleep_o |-> irq_o);

    p_irq_sticky_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_o && !irq_clr_i) |=> irq_o);

endmodule

bind aslp_rate_ctrl aslp_rate_ctrl_chk u_chk (.*);

// File: tb/aslp_rate_ctrl_tb_top.sv
module aslp_rate_ctrl_tb_top;

    logic       clk_i = 1'b0;
    logic       rst_i;
    logic       tick_i;
    logic [2:0] act_rate_i, sleep_rate_i;
    logic       sleep_en_i;
    logic [7:0] duration_i;
    logic [3:0] evt_i, evt_en_i, evt_wake_i;
    logic       irq_en_i, irq_clr_i;
    logic       asleep_o;
    logic [2:0] rate_o;
    logic       irq_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // model state
    bit m_sleep, m_irq;
    int m_q;

    always #2.5 clk_i = ~clk_i;

    aslp_rate_ctrl dut_i (.*);

    function automatic int steps_ticks(input logic [2:0] c);
        if (c <= 3'd4) return 1 << (8 - c);
        if (c == 3'd5) return 4;
        if (c == 3'd6) return 2;
        return 1;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Advance the model on the current inputs, take one edge, compare.
    task automatic step(input string tag);
        bit qual, wk, flip;
        qual = |(evt_i & evt_en_i);
        wk   = |(evt_i & evt_en_i & evt_wake_i);
        flip = 0;
        if (!m_sleep) begin
            if (qual || !sleep_en_i) m_q = 0;
            else if (tick_i) begin
                m_q++;
                if (m_q == int'(duration_i) * steps_ticks(act_rate_i) + 1) begin
                    m_sleep = 1; m_q = 0; flip = 1;
                end
            end
        end else if (wk || !sleep_en_i) begin
            m_sleep = 0; m_q = 0; flip = 1;
        end
        if (flip && irq_en_i) m_irq = 1;
        else if (irq_clr_i) m_irq = 0;
        @(posedge clk_i); #1;
        check(tag, "mode", asleep_o, m_sleep);
        check("R7", "rate", rate_o, m_sleep ? sleep_rate_i : act_rate_i);
        check("R9", "irq", irq_o, m_irq);
    endtask

    task automatic quiet_ticks(input int n, input string tag);
        tick_i = 1;
        for (int i = 0; i < n; i++) step(tag);
        tick_i = 0;
    endtask

    task automatic go_active();
        sleep_en_i = 0; step("R4");
        sleep_en_i = 1;
    endtask

    int cnt;

    initial begin
        void'($urandom(32'h5EED_A51));
        rst_i = 1; tick_i = 0; act_rate_i = 3'd3; sleep_rate_i = 3'd6;
        sleep_en_i = 0; duration_i = 0; evt_i = 0; evt_en_i = 4'hF;
        evt_wake_i = 4'hF; irq_en_i = 0; irq_clr_i = 0;
        repeat (3) @(posedge clk_i);
        #1;
        m_sleep = 0; m_irq = 0; m_q = 0;
        check("R1", "mode after reset", asleep_o, 0);
        check("R1", "irq after reset", irq_o, 0);
        check("R1", "rate after reset", rate_o, 3);
        rst_i = 0;
        step("R1");

        // R2: ticks-to-sleep at every rate with duration 2
        sleep_en_i = 1; duration_i = 8'd2;
        for (int c = 0; c < 8; c++) begin
            act_rate_i = 3'(c);
            go_active();
            cnt = 0; tick_i = 1;
            while (!asleep_o && cnt < 600) begin step("R2"); cnt++; end
            tick_i = 0;
            check("R2", "ticks to sleep", cnt, 2 * steps_ticks(3'(c)) + 1);
        end

        // R3: duration 0, sparse ticks
        go_active(); duration_i = 0; act_rate_i = 0;
        step("R3"); step("R3");
        check("R3", "no tick yet", asleep_o, 0);
        quiet_ticks(1, "R3");
        check("R3", "first quiet tick", asleep_o, 1);

        // R4: disabled sleep never sleeps; clearing it wakes
        sleep_en_i = 0; step("R4");
        check("R4", "wake on disable", asleep_o, 0);
        quiet_ticks(20, "R4");
        check("R4", "stays active", asleep_o, 0);
        sleep_en_i = 1;

        // R5: enabled event beats a tick, disabled source ignored
        duration_i = 1; act_rate_i = 3'd7;
        quiet_ticks(1, "R5");
        tick_i = 1; evt_i = 4'b0100; step("R5"); evt_i = 0;
        quiet_ticks(1, "R5");
        check("R5", "restart held off sleep", asleep_o, 0);
        evt_en_i = 4'b1011; evt_i = 4'b0100; tick_i = 1; step("R5");
        evt_i = 0; tick_i = 0;
        check("R5", "disabled source ignored", asleep_o, 1);
        evt_en_i = 4'hF;

        // R6: enabled but not wake-selected keeps sleep
        evt_wake_i = 4'b0001; evt_i = 4'b1000; step("R6"); evt_i = 0;
        check("R6", "non-wake event", asleep_o, 1);
        evt_i = 4'b0001; step("R6"); evt_i = 0;
        check("R6", "wake event", asleep_o, 0);

        // R10: full period after wake (D=1,T=1 -> 2 ticks)
        quiet_ticks(1, "R10");
        check("R10", "one tick after wake", asleep_o, 0);
        quiet_ticks(1, "R10");
        check("R10", "second tick", asleep_o, 1);

        // R8: flag off when disabled, on when enabled
        go_active();
        check("R8", "no flag when disabled", irq_o, 0);
        irq_en_i = 1; quiet_ticks(2, "R8");
        check("R8", "flag on sleep", irq_o, 1);

        // R9: clear, then clear coinciding with a transition
        irq_clr_i = 1; step("R9"); irq_clr_i = 0;
        check("R9", "cleared", irq_o, 0);
        evt_i = 4'b0001; irq_clr_i = 1; step("R9");
        evt_i = 0; irq_clr_i = 0;
        check("R9", "set beats clear", irq_o, 1);
        check("R8", "flag on wake", asleep_o, 0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            tick_i     = ($urandom % 3) == 0;
            evt_i      = (($urandom % 12) == 0) ? 4'($urandom) : 4'h0;
            irq_clr_i  = ($urandom % 10) == 0;
            if (($urandom % 50) == 0) irq_en_i = ~irq_en_i;
            if (($urandom % 40) == 0) evt_wake_i = 4'($urandom);
            if (($urandom % 200) == 0) sleep_en_i = 0;
            else if (!sleep_en_i && ($urandom % 4) == 0) sleep_en_i = 1;
            if (($urandom % 60) == 0) begin
                // config change only together with a forced restart
                act_rate_i = 3'($urandom); sleep_rate_i = 3'($urandom);
                duration_i = 8'($urandom % 4);
                evt_en_i = 4'($urandom) | 4'b0001; evt_i = evt_i | 4'b0001;
            end
            step("R2");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule